// File: doc/BRIEF.md
# Pixel Event Derandomizer with Column Chain Output

This block is the digital back end of one pixel in a column of detector pixels. A hit strobe from the analog front end claims one of several independent conversion slots. Each slot later reports a finished conversion carrying a timing stamp, a time-over-threshold value, a charge value and ancillary bits. Because there are several slots, a new hit can be accepted while earlier conversions are still running. Random arrivals are absorbed this way instead of being lost.

Finished events leave in the order their hits arrived. Each event is packed into 64-bit words and merged onto a daisy-chained column bus. On that bus every pixel passes along the traffic of the pixels above it and adds its own. By default an event takes two words. The first word holds timing and time-over-threshold, and the second holds charge and ancillary data. A single-word mode sends only the timing word, which halves the chain load per event. Every word carries the pixel address and first/last flags, so the column end can rebuild event boundaries. The mode input must only change while the pixel holds no pending event.

Top module: `pix_evt_chain`

## Requirements
- R1: After reset, `dn_valid_o` is 0, `lost_cnt_o` is 0, all slots are free and `up_ready_o` is 1.
- R2: A hit (`hit_i`=1) claims the lowest-numbered free slot. `hit_slot_o` shows that slot as a one-hot vector in the same cycle. A slot is free once its event's last word has been loaded into the output register. It is available for claiming from the next cycle on.
- R3: A hit that arrives while all slots are busy gets no slot (`hit_slot_o`=0). It increments `lost_cnt_o`, which saturates at 2^LOST_W-1 (255 by default).
- R4: Local events leave in hit-arrival order, whatever order their conversions finish in. An event leaves only after its slot has reported a conversion.
- R5: In two-word mode (`mode_single_i`=0) an event is two words. Word bit 63 is the first flag, bit 62 is the last flag, bits 61:57 are the pixel address and bits 56:0 are the payload. Word one has first=1, last=0 and payload {timing[31:0], tot[15:0]} zero-extended. Word two has first=0, last=1 and payload {charge[15:0], ancillary[15:0]} zero-extended.
- R6: In single-word mode (`mode_single_i`=1) an event is one word with first=1 and last=1 and the timing payload of R5.
- R7: Upstream words are passed down unchanged and in order. When no local event is part-way through, `up_ready_o` equals (!`dn_valid_o` || `dn_ready_i`), so upstream takes priority over a waiting local word.
- R8: No other word enters the chain between the two words of a local event. While a local event is part-way through, `up_ready_o` is 0.
- R9: While `dn_valid_o`=1 and `dn_ready_i`=0, `dn_valid_o` and `dn_data_o` hold their values.
- R10: A conversion report on a slot that is not busy has no effect. A later hit that claims that slot produces no output until a fresh report arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_single_i | input | 1 | 1 = timing word only per event |
| hit_i | input | 1 | New hit from the front end |
| hit_slot_o | output | NSLOT | One-hot slot claimed by the current hit, 0 if dropped |
| lost_cnt_o | output | LOST_W | Saturating count of dropped hits |
| conv_done_i | input | NSLOT | Per-slot conversion-finished strobe |
| conv_time_i | input | NSLOT x TIME_W | Per-slot timing stamp |
| conv_tot_i | input | NSLOT x TOT_W | Per-slot time-over-threshold |
| conv_chg_i | input | NSLOT x CHG_W | Per-slot charge value |
| conv_anc_i | input | NSLOT x ANC_W | Per-slot ancillary bits |
| up_data_i | input | WORD_W | Word from the pixel above |
| up_valid_i | input | 1 | Upstream word valid |
| up_ready_o | output | 1 | Upstream word accepted this cycle when valid |
| dn_data_o | output | WORD_W | Word toward the column end |
| dn_valid_o | output | 1 | Downstream word valid |
| dn_ready_i | input | 1 | Downstream accepts the word |

## Verification
Two pairs of functions can fall in the same cycle. An upstream word can compete with a waiting local word, including the second word of a local event. A new hit can arrive in the cycle that an old slot retires. Seeded random traffic keeps upstream valid high most of the time while hits arrive densely with short and long conversion times, so both pairs collide often. The bench rebuilds every slot, the claim order and the priority state from the port traffic alone. It then judges each claimed slot, each `up_ready_o` value and each word on the chain against that model, word by word.

// File: rtl/pix_evt_pkg.sv
package pix_evt_pkg;

   // Flag bits at the top of every chain word: first, then last.
   localparam int unsigned FLAG_W = 2;

   // Source loaded into the chain output register.
   typedef enum logic [1:0] {
      SRC_IDLE  = 2'd0,
      SRC_UP    = 2'd1,
      SRC_LOCAL = 2'd2
   } chain_src_e;

endpackage

// File: rtl/pix_slot_alloc.sv
module pix_slot_alloc #(
   parameter int unsigned NSLOT  = 4,
   parameter int unsigned LOST_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hit_i,
   input  logic [NSLOT-1:0]  busy_i,
   output logic [NSLOT-1:0]  grant_o,
   output logic [LOST_W-1:0] lost_o
);

   localparam logic [LOST_W-1:0] LOST_MAX = '1;

   logic found;
   logic all_busy;

   // Lowest-numbered free slot wins.
   always_comb begin
      grant_o = '0;
      found   = 1'b0;
      for (int i = 0; i < int'(NSLOT); i++) begin
         if (!busy_i[i] && !found) begin
            grant_o[i] = hit_i;
            found      = 1'b1;
         end
      end
   end

   assign all_busy = &busy_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lost_o <= '0;
      end else if (hit_i && all_busy && (lost_o != LOST_MAX)) begin
         lost_o <= lost_o + 1'b1;
      end
   end

   assert_grant_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_o));

   assert_grant_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_o & busy_i) == '0);

   assert_lost_monotone_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (lost_o >= $past(lost_o)));

endmodule

// File: rtl/pix_age_queue.sv
module pix_age_queue #(
   parameter int unsigned DEPTH = 4,
   parameter int unsigned IDX_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_i,
   input  logic [IDX_W-1:0] push_idx_i,
   input  logic             pop_i,
   output logic [IDX_W-1:0] head_o,
   output logic             empty_o
);

   localparam int unsigned CNT_W = $clog2(DEPTH + 1);

   logic [IDX_W-1:0] q [DEPTH];
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] wpos;

   assign head_o  = q[0];
   assign empty_o = (cnt == '0);
   assign wpos    = pop_i ? (cnt - 1'b1) : cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
         for (int i = 0; i < int'(DEPTH); i++) q[i] <= '0;
      end else begin
         if (pop_i) begin
            for (int i = 0; i < int'(DEPTH) - 1; i++) q[i] <= q[i+1];
         end
         if (push_i) begin
            for (int i = 0; i < int'(DEPTH); i++) begin
               if (CNT_W'(i) == wpos) q[i] <= push_idx_i;
            end
         end
         if (push_i && !pop_i) cnt <= cnt + 1'b1;
         else if (pop_i && !push_i) cnt <= cnt - 1'b1;
      end
   end

   assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && !pop_i) |-> (cnt < CNT_W'(DEPTH)));

   assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
      pop_i |-> !empty_o);

endmodule

// File: rtl/pix_chain_arb.sv
module pix_chain_arb
   import pix_evt_pkg::*;
#(
   parameter int unsigned WORD_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] loc_word_i,
   input  logic              loc_valid_i,
   input  logic              loc_hold_i,
   output logic              loc_take_o,
   input  logic [WORD_W-1:0] up_data_i,
   input  logic              up_valid_i,
   output logic              up_ready_o,
   output logic [WORD_W-1:0] dn_data_o,
   output logic              dn_valid_o,
   input  logic              dn_ready_i
);

   chain_src_e src;
   logic       can_load;

   assign can_load = !dn_valid_o || dn_ready_i;

   always_comb begin
      src = SRC_IDLE;
      if (can_load) begin
         if (loc_hold_i) begin
            if (loc_valid_i) src = SRC_LOCAL;
         end else if (up_valid_i) begin
            src = SRC_UP;
         end else if (loc_valid_i) begin
            src = SRC_LOCAL;
         end
      end
   end

   assign up_ready_o = can_load && !loc_hold_i;
   assign loc_take_o = (src == SRC_LOCAL);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dn_valid_o <= 1'b0;
         dn_data_o  <= '0;
      end else if (can_load) begin
         dn_valid_o <= (src != SRC_IDLE);
         if (src == SRC_UP)         dn_data_o <= up_data_i;
         else if (src == SRC_LOCAL) dn_data_o <= loc_word_i;
      end
   end

   assert_hold_output_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (dn_valid_o && !dn_ready_i) |=> (dn_valid_o && $stable(dn_data_o)));

   assert_up_forward_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (up_valid_i && up_ready_o) |=> (dn_valid_o && dn_data_o == $past(up_data_i)));

endmodule

// File: rtl/pix_evt_chain.sv
module pix_evt_chain
   import pix_evt_pkg::*;
#(
   parameter int unsigned NSLOT    = 4,
   parameter int unsigned WORD_W   = 64,
   parameter int unsigned ADDR_W   = 5,
   parameter int unsigned PIX_ADDR = 7,
   parameter int unsigned TIME_W   = 32,
   parameter int unsigned TOT_W    = 16,
   parameter int unsigned CHG_W    = 16,
   parameter int unsigned ANC_W    = 16,
   parameter int unsigned LOST_W   = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          mode_single_i,
   input  logic                          hit_i,
   output logic [NSLOT-1:0]              hit_slot_o,
   output logic [LOST_W-1:0]             lost_cnt_o,
   input  logic [NSLOT-1:0]              conv_done_i,
   input  logic [NSLOT-1:0][TIME_W-1:0]  conv_time_i,
   input  logic [NSLOT-1:0][TOT_W-1:0]   conv_tot_i,
   input  logic [NSLOT-1:0][CHG_W-1:0]   conv_chg_i,
   input  logic [NSLOT-1:0][ANC_W-1:0]   conv_anc_i,
   input  logic [WORD_W-1:0]             up_data_i,
   input  logic                          up_valid_i,
   output logic                          up_ready_o,
   output logic [WORD_W-1:0]             dn_data_o,
   output logic                          dn_valid_o,
   input  logic                          dn_ready_i
);

   localparam int unsigned IDX_W = (NSLOT > 1) ? $clog2(NSLOT) : 1;
   localparam int unsigned PAY_W = WORD_W - FLAG_W - ADDR_W;

   // Elaboration-time parameter checks.
   if (NSLOT < 2) begin : g_bad_nslot
      $error("pix_evt_chain: NSLOT must be at least 2");
   end
   if (TIME_W + TOT_W > PAY_W) begin : g_bad_word_a
      $error("pix_evt_chain: timing word payload does not fit");
   end
   if (CHG_W + ANC_W > PAY_W) begin : g_bad_word_b
      $error("pix_evt_chain: charge word payload does not fit");
   end
   if (PIX_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
      $error("pix_evt_chain: PIX_ADDR exceeds ADDR_W");
   end

   logic [NSLOT-1:0]             busy_q, done_q, grant;
   logic [NSLOT-1:0][TIME_W-1:0] time_q;
   logic [NSLOT-1:0][TOT_W-1:0]  tot_q;
   logic [NSLOT-1:0][CHG_W-1:0]  chg_q;
   logic [NSLOT-1:0][ANC_W-1:0]  anc_q;

   logic [IDX_W-1:0]  head_idx, grant_idx;
   logic              q_empty;
   logic              wsel_q;
   logic              loc_valid, loc_last, loc_take, retire;
   logic [PAY_W-1:0]  pay_a, pay_b;
   logic [WORD_W-1:0] loc_word;

   pix_slot_alloc #(.NSLOT(NSLOT), .LOST_W(LOST_W)) u_alloc (
      .clk     (clk),
      .rst_n   (rst_n),
      .hit_i   (hit_i),
      .busy_i  (busy_q),
      .grant_o (grant),
      .lost_o  (lost_cnt_o)
   );

   assign hit_slot_o = grant;

   always_comb begin
      grant_idx = '0;
      for (int i = 0; i < int'(NSLOT); i++) begin
         if (grant[i]) grant_idx = IDX_W'(i);
      end
   end

   pix_age_queue #(.DEPTH(NSLOT), .IDX_W(IDX_W)) u_order (
      .clk        (clk),
      .rst_n      (rst_n),
      .push_i     (|grant),
      .push_idx_i (grant_idx),
      .pop_i      (retire),
      .head_o     (head_idx),
      .empty_o    (q_empty)
   );

   // Slot state: claimed by a grant, filled by a conversion report,
   // released when the event's last word is loaded downstream.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= '0;
         done_q <= '0;
         time_q <= '0;
         tot_q  <= '0;
         chg_q  <= '0;
         anc_q  <= '0;
      end else begin
         for (int s = 0; s < int'(NSLOT); s++) begin
            if (grant[s]) begin
               busy_q[s] <= 1'b1;
            end else if (retire && (head_idx == IDX_W'(s))) begin
               busy_q[s] <= 1'b0;
               done_q[s] <= 1'b0;
            end
            if (conv_done_i[s] && busy_q[s] && !done_q[s]) begin
               done_q[s] <= 1'b1;
               time_q[s] <= conv_time_i[s];
               tot_q[s]  <= conv_tot_i[s];
               chg_q[s]  <= conv_chg_i[s];
               anc_q[s]  <= conv_anc_i[s];
            end
         end
      end
   end

   assign loc_valid = !q_empty && done_q[head_idx];
   assign loc_last  = mode_single_i || wsel_q;
   assign pay_a     = PAY_W'({time_q[head_idx], tot_q[head_idx]});
   assign pay_b     = PAY_W'({chg_q[head_idx], anc_q[head_idx]});
   assign loc_word  = {!wsel_q, loc_last, ADDR_W'(PIX_ADDR), (wsel_q ? pay_b : pay_a)};
   assign retire    = loc_take && loc_last;

   always_ff @(posedge clk) begin
      if (!rst_n)        wsel_q <= 1'b0;
      else if (loc_take) wsel_q <= !loc_last;
   end

   pix_chain_arb #(.WORD_W(WORD_W)) u_arb (
      .clk         (clk),
      .rst_n       (rst_n),
      .loc_word_i  (loc_word),
      .loc_valid_i (loc_valid),
      .loc_hold_i  (wsel_q),
      .loc_take_o  (loc_take),
      .up_data_i   (up_data_i),
      .up_valid_i  (up_valid_i),
      .up_ready_o  (up_ready_o),
      .dn_data_o   (dn_data_o),
      .dn_valid_o  (dn_valid_o),
      .dn_ready_i  (dn_ready_i)
   );

   assert_no_split_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wsel_q |-> !(up_valid_i && up_ready_o));

   assert_head_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
      loc_take |-> (busy_q[head_idx] && done_q[head_idx]));

   assert_slot_freed_R2: assert property (@(posedge clk) disable iff (!rst_n)
      retire |=> !busy_q[$past(head_idx)] || $past(grant[head_idx]));

   assert_ignore_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q & ~busy_q) == '0);

endmodule

// File: tb/sim_pix_evt_chain.sv
`timescale 1ns/1ps
module sim_pix_evt_chain;

   localparam int NS  = 4;
   localparam int PIX = 7;
   localparam int UPA = 20;

   logic clk = 1'b0;
   logic rst_n;
   logic mode_single_i;
   logic hit_i;
   logic [NS-1:0] hit_slot_o;
   logic [7:0] lost_cnt_o;
   logic [NS-1:0] conv_done_i;
   logic [NS-1:0][31:0] conv_time_i;
   logic [NS-1:0][15:0] conv_tot_i;
   logic [NS-1:0][15:0] conv_chg_i;
   logic [NS-1:0][15:0] conv_anc_i;
   logic [63:0] up_data_i;
   logic up_valid_i;
   logic up_ready_o;
   logic [63:0] dn_data_o;
   logic dn_valid_o;
   logic dn_ready_i;

   always #2 clk = ~clk;   // 250 MHz

   pix_evt_chain #(.PIX_ADDR(PIX)) u0 (
      .clk(clk), .rst_n(rst_n), .mode_single_i(mode_single_i),
      .hit_i(hit_i), .hit_slot_o(hit_slot_o), .lost_cnt_o(lost_cnt_o),
      .conv_done_i(conv_done_i), .conv_time_i(conv_time_i), .conv_tot_i(conv_tot_i),
      .conv_chg_i(conv_chg_i), .conv_anc_i(conv_anc_i),
      .up_data_i(up_data_i), .up_valid_i(up_valid_i), .up_ready_o(up_ready_o),
      .dn_data_o(dn_data_o), .dn_valid_o(dn_valid_o), .dn_ready_i(dn_ready_i)
   );

   int n_chk = 0, n_bad = 0;
   bit finished = 0;

   // bench model
   bit          busy_m [NS];
   int          cd     [NS];
   logic [31:0] t_m    [NS];
   logic [15:0] o_m    [NS], c_m [NS], a_m [NS];
   int          order_q[$];
   logic [63:0] up_q   [$];
   int          wsel_m = 0;
   bit          mid_m = 0;
   int          lost_m = 0;
   bit          prev_v = 0, prev_acc = 0;
   logic [63:0] prev_d = '0;
   int          up_seq = 1;
   bit          up_pend = 0;
   int p_hit = 0, p_up = 0, p_rdy = 100, dmin = 2, dmax = 8;
   logic [NS-1:0] extra_done = '0;
   bit force_hit = 0;

   function automatic logic [63:0] mkw(bit f, bit l, int addr, logic [56:0] pay);
      return {f, l, 5'(addr), pay};
   endfunction

   function automatic logic [56:0] pay_a(int s);
      return 57'({t_m[s], o_m[s]});
   endfunction

   function automatic logic [56:0] pay_b(int s);
      return 57'({c_m[s], a_m[s]});
   endfunction

   task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   task automatic on_new_word(logic [63:0] w);
      if (int'(w[61:57]) == UPA) begin
         chk(!mid_m, "R8 upstream inside local event", w, 64'h0);
         if (up_q.size() > 0) begin
            chk(w == up_q[0], "R7 upstream order", w, up_q[0]);
            void'(up_q.pop_front());
         end else begin
            chk(0, "R7 unexpected upstream word", w, 64'h0);
         end
      end else if (order_q.size() == 0) begin
         chk(0, "R4 local word with no event", w, 64'h0);
      end else begin
         int h;
         logic [63:0] e;
         h = order_q[0];
         if (wsel_m == 0) begin
            if (mode_single_i) begin
               e = mkw(1, 1, PIX, pay_a(h));
               chk(w == e, "R6 single word", w, e);
            end else begin
               e = mkw(1, 0, PIX, pay_a(h));
               chk(w == e, "R5/R4 first word", w, e);
            end
         end else begin
            e = mkw(0, 1, PIX, pay_b(h));
            chk(w == e, "R5/R8 second word", w, e);
         end
         if (w[62]) begin
            void'(order_q.pop_front());
            busy_m[h] = 0;
            wsel_m = 0;
            mid_m = 0;
         end else begin
            wsel_m = 1;
            mid_m = 1;
         end
      end
   endtask

   task automatic step();
      bit exp_ur;
      int f;
      @(negedge clk);
      if (dn_valid_o && (!prev_v || prev_acc)) on_new_word(dn_data_o);
      if (prev_v && !prev_acc)
         chk(dn_valid_o && dn_data_o == prev_d, "R9 hold", dn_data_o, prev_d);
      // drive inputs
      hit_i = force_hit || ($urandom_range(99) < p_hit);
      for (int s = 0; s < NS; s++) begin
         conv_done_i[s] = extra_done[s];
         if (busy_m[s] && cd[s] == 0) begin
            conv_done_i[s] = 1'b1;
            cd[s] = -1;
         end else if (cd[s] > 0) begin
            cd[s]--;
         end
      end
      if (!up_pend && ($urandom_range(99) < p_up)) begin
         up_pend = 1;
         up_data_i = mkw(1, 1, UPA, 57'(up_seq));
         up_seq++;
      end
      up_valid_i = up_pend;
      dn_ready_i = ($urandom_range(99) < p_rdy);
      #1;
      exp_ur = (!dn_valid_o || dn_ready_i) && !mid_m;
      chk(up_ready_o == exp_ur, "R7/R8 up_ready", 64'(up_ready_o), 64'(exp_ur));
      if (up_valid_i && up_ready_o) begin
         up_q.push_back(up_data_i);
         up_pend = 0;
      end
      if (hit_i) begin
         f = -1;
         for (int s = NS - 1; s >= 0; s--) if (!busy_m[s]) f = s;
         if (f < 0) begin
            chk(hit_slot_o == '0, "R3 dropped hit", 64'(hit_slot_o), 64'h0);
            lost_m++;
         end else begin
            chk(hit_slot_o == NS'(1 << f), "R2 lowest free slot", 64'(hit_slot_o), 64'(1 << f));
            busy_m[f] = 1;
            order_q.push_back(f);
            cd[f] = $urandom_range(dmax, dmin);
            t_m[f] = $urandom();
            o_m[f] = 16'($urandom());
            c_m[f] = 16'($urandom());
            a_m[f] = 16'($urandom());
            conv_time_i[f] = t_m[f];
            conv_tot_i[f]  = o_m[f];
            conv_chg_i[f]  = c_m[f];
            conv_anc_i[f]  = a_m[f];
         end
      end
      prev_v   = dn_valid_o;
      prev_acc = dn_valid_o && dn_ready_i;
      prev_d   = dn_data_o;
   endtask

   task automatic drain();
      p_hit = 0; p_up = 0; p_rdy = 100;
      for (int i = 0; i < 400; i++) begin
         if (order_q.size() == 0 && up_q.size() == 0 && !up_pend && !dn_valid_o) break;
         step();
      end
      chk(order_q.size() == 0 && up_q.size() == 0, "R4 drained", 64'(order_q.size()), 64'h0);
   endtask

   task automatic run(int n, int ph, int pu, int pr, int d0, int d1);
      p_hit = ph; p_up = pu; p_rdy = pr; dmin = d0; dmax = d1;
      for (int i = 0; i < n; i++) step();
   endtask

   initial begin
      #(4 * 150000);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
   end

   initial begin
      void'($urandom(32'd2718));
      for (int s = 0; s < NS; s++) begin busy_m[s] = 0; cd[s] = -1; end
      rst_n = 0; mode_single_i = 0; hit_i = 0; conv_done_i = '0;
      conv_time_i = '0; conv_tot_i = '0; conv_chg_i = '0; conv_anc_i = '0;
      up_data_i = '0; up_valid_i = 0; dn_ready_i = 1;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1;
      #1;
      // R1 reset state
      chk(!dn_valid_o, "R1 dn_valid", 64'(dn_valid_o), 64'h0);
      chk(lost_cnt_o == 0, "R1 lost", 64'(lost_cnt_o), 64'h0);
      chk(up_ready_o, "R1 up_ready", 64'(up_ready_o), 64'h1);
      hit_i = 1; #1;
      chk(hit_slot_o == 4'b0001, "R1 all slots free", 64'(hit_slot_o), 64'h1);
      hit_i = 0;

      // directed: one event, two-word mode, no other traffic
      force_hit = 1; step(); force_hit = 0;
      run(20, 0, 0, 100, 3, 3);

      // random two-word, short conversions
      run(3000, 30, 30, 70, 2, 10);
      drain();
      // single-word mode, long conversions
      mode_single_i = 1;
      run(3000, 35, 40, 70, 4, 20);
      drain();
      // two-word, heavy collisions of upstream with local traffic
      mode_single_i = 0;
      run(3000, 50, 85, 60, 2, 12);
      drain();

      // R10: report on a free slot is ignored
      extra_done = 4'b0001; step(); extra_done = '0;
      dmin = 30; dmax = 30;
      force_hit = 1; step(); force_hit = 0;
      for (int i = 0; i < 8; i++) begin
         step();
         chk(!dn_valid_o, "R10 no output before real report", 64'(dn_valid_o), 64'h0);
      end
      drain();

      chk(lost_cnt_o == 8'(lost_m > 255 ? 255 : lost_m), "R3 lost count",
          64'(lost_cnt_o), 64'(lost_m > 255 ? 255 : lost_m));
      // R3 saturation: slots held busy, many hits
      run(320, 100, 0, 100, 5000, 5000);
      chk(lost_cnt_o == 8'd255, "R3 saturation", 64'(lost_cnt_o), 64'd255);
      summary();
   end

endmodule